// File: doc/BRIEF.md
# Response Ring Write Engine

This block sits on the controller side of a circular response queue kept in system memory. Responses of 64 bits arrive on a valid/ready port. For each one the engine first moves its hardware-owned write index to the next slot, wrapping at the selected depth. It then writes the response to memory at `base + 8 * index` over a single-beat write port. The index is published only once that memory write has been acknowledged.

Software reads the write index from a register and keeps its own consumer position. Any difference between the two means entries are waiting. Software programs the ring base, picks a depth of 2, 16 or 256 entries, starts and stops the engine, and can return the index to zero. It also sets a response count. Once that many responses have been stored, a sticky status flag is raised and drives the interrupt line. Software clears the flag by writing 1 to it.

The register window is 16 bytes of 32-bit words with byte enables. Reads are combinational from the address.

Top module: `rsp_ring_dma`

## Requirements
- R1: After reset the write index is 0, the engine is stopped, the interrupt count and status flag are 0, `irq` and `rspReady` are low, and the word at 0xC reads 0x0070_0000.
- R2: The word at 0x0 holds the low base address. Its bits 6:0 always read as zero and are treated as zero when forming memory addresses. The word at 0x4 holds the upper 32 address bits.
- R3: While bit 1 of the byte at 0xC (run) is clear, `rspReady` stays low and no new memory write starts.
- R4: An accepted response is written with `memWrData` equal to the response and `memWrAddr = base + 8*((index+1) mod depth)`.
- R5: The write index takes its new value only in the cycle after the memory write handshake (`memWrValid` and `memWrReady`). While `memWrReady` is low, the request, address and data are held. The index reads back in bits 7:0 of the word at 0x8, and bits 15:8 read as zero.
- R6: Bits 1:0 of the byte at 0xE select the depth: 00 selects 2, 01 selects 16, 10 selects 256. A write of 11 is ignored. Bits 7:4 of that byte read as 0111.
- R7: A write of 1 to bit 15 of the word at 0x8 returns the write index to 0.
- R8: The run bit read back stays 1 after software clears it until the outstanding memory write completes. After that it reads 0.
- R9: The 16-bit field at offset 0xA (bits 31:16 of word 0x8) sets a response count N. After every N stored responses, bit 0 of the byte at 0xD (bit 8 of word 0xC) sets, `irq` follows it, and the internal count restarts.
- R10: A write of 1 to bit 0 of the byte at 0xD clears the status flag. When N is 0 the flag never sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register byte address (word aligned for writes) |
| regWrData | input | 32 | Register write data |
| regByteEn | input | 4 | Byte enables for the write |
| regRdData | output | 32 | Register read data for regAddr |
| rspValid | input | 1 | Response offered |
| rspData | input | 64 | Response payload |
| rspReady | output | 1 | Response accepted this cycle when high with rspValid |
| memWrValid | output | 1 | Memory write request |
| memWrAddr | output | 64 | Memory byte address |
| memWrData | output | 64 | Memory write data |
| memWrReady | input | 1 | Memory write acknowledge |
| irq | output | 1 | Response-count interrupt |

## Verification
The bench drives responses at all three depths and follows the index across each wrap point. An engine that wrapped at the wrong depth, or that stored a response before moving its index, would write to the wrong address and publish the wrong index. It stalls the memory acknowledge for several cycles and checks that the index has not moved. A design that published early would let software read a slot that holds nothing yet. It also clears run in the middle of a write. A control bit that echoed the software value would report the engine stopped while a write is still in flight. Finally it checks the interrupt threshold, the restart of the count, write-1-clear, the zero-count case and the reserved depth code, where a wrong design would raise the interrupt one response off, never raise it again, or corrupt the depth.

// File: rtl/rsp_ring_pkg.sv
package rsp_ring_pkg;

  typedef struct packed {
    logic accept;
    logic commit;
  } ringStrobe_t;

  localparam logic [3:0] SIZE_CAP = 4'b0111;

  localparam logic [1:0] SEL_2   = 2'b00;
  localparam logic [1:0] SEL_16  = 2'b01;
  localparam logic [1:0] SEL_256 = 2'b10;

  function automatic logic [7:0] depthMask(input logic [1:0] sel);
    case (sel)
      SEL_2:   depthMask = 8'h01;
      SEL_16:  depthMask = 8'h0F;
      default: depthMask = 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/rsp_ring_ctrl.sv
module rsp_ring_ctrl
  import rsp_ring_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        runReq,
  input  logic        rspValid,
  input  logic        memWrReady,
  output logic        rspReady,
  output logic        memWrValid,
  output logic        busy,
  output ringStrobe_t strobe
);

  typedef enum logic {ST_IDLE, ST_WRITE} ctrlState_t;
  ctrlState_t state, stateNext;

  always_comb begin
    rspReady      = (state == ST_IDLE) && runReq;
    memWrValid    = (state == ST_WRITE);
    busy          = (state == ST_WRITE);
    strobe.accept = rspReady && rspValid;
    strobe.commit = memWrValid && memWrReady;
    stateNext     = state;
    if (strobe.accept)      stateNext = ST_WRITE;
    else if (strobe.commit) stateNext = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/rsp_ring_dp.sv
module rsp_ring_dp
  import rsp_ring_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64,
  parameter int PTR_W  = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [3:0]        regAddr,
  input  logic [31:0]       regWrData,
  input  logic [3:0]        regByteEn,
  output logic [31:0]       regRdData,
  input  logic [DATA_W-1:0] rspData,
  input  ringStrobe_t       strobe,
  input  logic              busy,
  output logic              runReq,
  output logic [PTR_W-1:0]  wrPtr,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              irq
);

  localparam int ALIGN_W = 7;
  localparam int SLOT_SH = 3;
  localparam int PAD_W   = ADDR_W - PTR_W - SLOT_SH;

  logic [31:0]       baseLo, baseHi;
  logic [CNT_W-1:0]  intCount, rspCount;
  logic [1:0]        sizeSel;
  logic              statusFlag;
  logic [PTR_W-1:0]  heldIdx, nextIdx, ptrMask;
  logic [ADDR_W-1:0] ringBase;
  logic [1:0]        wordSel;
  logic              wrWord0, wrWord1, wrWord2, wrWord3;
  logic              ptrClear, statusClear, countHit;

  always_comb begin
    wordSel     = regAddr[3:2];
    wrWord0     = regWrEn && (regAddr[1:0] == 2'b00) && (wordSel == 2'd0);
    wrWord1     = regWrEn && (regAddr[1:0] == 2'b00) && (wordSel == 2'd1);
    wrWord2     = regWrEn && (regAddr[1:0] == 2'b00) && (wordSel == 2'd2);
    wrWord3     = regWrEn && (regAddr[1:0] == 2'b00) && (wordSel == 2'd3);
    ptrClear    = wrWord2 && regByteEn[1] && regWrData[15];
    statusClear = wrWord3 && regByteEn[1] && regWrData[8];
    ptrMask     = PTR_W'(depthMask(sizeSel));
    nextIdx     = (wrPtr + 1'b1) & ptrMask;
    ringBase    = {baseHi, baseLo[31:ALIGN_W], {ALIGN_W{1'b0}}};
    countHit    = (intCount != '0) && ((rspCount + 1'b1) == intCount);
  end

  // software-written registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseLo   <= '0;
      baseHi   <= '0;
      intCount <= '0;
      runReq   <= 1'b0;
      sizeSel  <= SEL_2;
    end else begin
      for (int b = 0; b < 4; b++) begin
        if (wrWord0 && regByteEn[b]) baseLo[8*b +: 8] <= regWrData[8*b +: 8];
        if (wrWord1 && regByteEn[b]) baseHi[8*b +: 8] <= regWrData[8*b +: 8];
      end
      if (wrWord2 && regByteEn[2]) intCount[7:0]  <= regWrData[23:16];
      if (wrWord2 && regByteEn[3]) intCount[15:8] <= regWrData[31:24];
      if (wrWord3 && regByteEn[0]) runReq <= regWrData[1];
      if (wrWord3 && regByteEn[2] && (regWrData[17:16] != 2'b11))
        sizeSel <= regWrData[17:16];
    end
  end

  // index, capture and response counting
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr      <= '0;
      heldIdx    <= '0;
      memWrAddr  <= '0;
      memWrData  <= '0;
      rspCount   <= '0;
      statusFlag <= 1'b0;
    end else begin
      if (strobe.accept) begin
        heldIdx   <= nextIdx;
        memWrData <= rspData;
        memWrAddr <= ringBase + {{PAD_W{1'b0}}, nextIdx, {SLOT_SH{1'b0}}};
      end
      if (ptrClear)           wrPtr <= '0;
      else if (strobe.commit) wrPtr <= heldIdx;
      if (strobe.commit && intCount != '0) begin
        if (countHit) rspCount <= '0;
        else          rspCount <= rspCount + 1'b1;
      end
      if (strobe.commit && countHit) statusFlag <= 1'b1;
      else if (statusClear)          statusFlag <= 1'b0;
    end
  end

  always_comb begin
    case (wordSel)
      2'd0:    regRdData = {baseLo[31:ALIGN_W], {ALIGN_W{1'b0}}};
      2'd1:    regRdData = baseHi;
      2'd2:    regRdData = {intCount, {(16-PTR_W){1'b0}}, wrPtr};
      default: regRdData = {8'h00, SIZE_CAP, 2'b00, sizeSel,
                            7'b0, statusFlag, 6'b0, runReq || busy, 1'b0};
    endcase
    irq = statusFlag;
  end

endmodule

// File: rtl/rsp_ring_dma.sv
module rsp_ring_dma
  import rsp_ring_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [3:0]        regAddr,
  input  logic [31:0]       regWrData,
  input  logic [3:0]        regByteEn,
  output logic [31:0]       regRdData,
  input  logic              rspValid,
  input  logic [DATA_W-1:0] rspData,
  output logic              rspReady,
  output logic              memWrValid,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  input  logic              memWrReady,
  output logic              irq
);

  localparam int PTR_W = 8;

  ringStrobe_t      strobe;
  logic             runReq, busy;
  logic [PTR_W-1:0] wrPtr;

  rsp_ring_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .runReq(runReq), .rspValid(rspValid),
    .memWrReady(memWrReady), .rspReady(rspReady), .memWrValid(memWrValid),
    .busy(busy), .strobe(strobe)
  );

  rsp_ring_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W)) dp_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regByteEn(regByteEn), .regRdData(regRdData),
    .rspData(rspData), .strobe(strobe), .busy(busy), .runReq(runReq),
    .wrPtr(wrPtr), .memWrAddr(memWrAddr), .memWrData(memWrData), .irq(irq)
  );

endmodule

// File: rtl/rsp_ring_dma_chk.sv
module rsp_ring_dma_chk #(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              rspValid,
  input logic              rspReady,
  input logic              memWrValid,
  input logic              memWrReady,
  input logic [ADDR_W-1:0] memWrAddr,
  input logic [DATA_W-1:0] memWrData,
  input logic              irq,
  input logic              runReq,
  input logic [7:0]        wrPtr
);

  assert_ready_needs_run_R3: assert property (@(posedge clk) disable iff (!rstN)
    rspReady |-> runReq);

  assert_no_start_stopped_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!runReq && !memWrValid) |=> !memWrValid);

  assert_accept_starts_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspReady) |=> memWrValid);

  assert_write_held_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memWrValid && !memWrReady) |=> (memWrValid && $stable(memWrAddr) && $stable(memWrData)));

  assert_ptr_after_ack_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((wrPtr != $past(wrPtr)) && (wrPtr != 8'd0)) |-> $past(memWrValid && memWrReady));

  assert_irq_on_store_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(memWrValid && memWrReady));

endmodule

bind rsp_ring_dma rsp_ring_dma_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .rspValid(rspValid), .rspReady(rspReady),
  .memWrValid(memWrValid), .memWrReady(memWrReady), .memWrAddr(memWrAddr),
  .memWrData(memWrData), .irq(irq), .runReq(runReq), .wrPtr(wrPtr)
);

// File: tb/rsp_ring_dma_tb_top.sv
module rsp_ring_dma_tb_top;

  localparam time CLK_P = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [3:0]  regByteEn = '0;
  logic [31:0] regRdData;
  logic        rspValid = 1'b0;
  logic [63:0] rspData = '0;
  logic        rspReady;
  logic        memWrValid;
  logic [63:0] memWrAddr;
  logic [63:0] memWrData;
  logic        memWrReady = 1'b0;
  logic        irq;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;
  logic [7:0] curIdx = '0;

  localparam logic [63:0] BASE = 64'h0000_0012_3456_7880;

  always #(CLK_P/2) clk = ~clk;

  rsp_ring_dma dut_i (.*);

  typedef struct packed {
    logic [63:0] data;
    logic [3:0]  stall;
    logic [7:0]  idx;
    logic        irqExp;
  } vec_t;

  // depth 2, interrupt every 3 responses
  localparam vec_t VECS [5] = '{
    '{64'hA5A5_0000_0000_0001, 4'd0, 8'd1, 1'b0},
    '{64'hFFFF_FFFF_FFFF_FFFF, 4'd3, 8'd0, 1'b0},
    '{64'h0123_4567_89AB_CDEF, 4'd1, 8'd1, 1'b1},
    '{64'h0000_0000_0000_0000, 4'd5, 8'd0, 1'b1},
    '{64'h8000_0000_0000_0001, 4'd2, 8'd1, 1'b1}
  };

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d; regByteEn = be;
    @(negedge clk);
    regWrEn = 1'b0; regByteEn = '0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  // offer one response, hold the acknowledge low for 'stall' cycles
  task automatic sendRsp(input logic [63:0] d, input int stall, input logic [7:0] expIdx);
    logic [31:0] rd;
    @(negedge clk);
    rspValid = 1'b1; rspData = d;
    while (!rspReady) @(negedge clk);
    @(negedge clk);
    rspValid = 1'b0;
    check(memWrValid === 1'b1, "R4 write request", 64'(memWrValid), 64'd1);
    check(memWrAddr === BASE + 64'(expIdx) * 8, "R4 slot address", memWrAddr, BASE + 64'(expIdx) * 8);
    check(memWrData === d, "R4 slot data", memWrData, d);
    for (int s = 0; s < stall; s++) begin
      regRead(4'h8, rd);
      check(rd[7:0] === curIdx, "R5 index held before ack", 64'(rd[7:0]), 64'(curIdx));
      @(negedge clk);
      check(memWrValid === 1'b1, "R5 request held", 64'(memWrValid), 64'd1);
    end
    memWrReady = 1'b1;
    @(negedge clk);
    memWrReady = 1'b0;
    regRead(4'h8, rd);
    check(rd[15:0] === {8'h00, expIdx}, "R5 index after ack", 64'(rd[15:0]), 64'(expIdx));
    curIdx = expIdx;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    check(rspReady === 1'b0 && irq === 1'b0, "R1 outputs after reset", {62'b0, rspReady, irq}, 64'd0);
    regRead(4'h8, rd);
    check(rd === 32'h0, "R1 index and count", 64'(rd), 64'd0);
    regRead(4'hC, rd);
    check(rd === 32'h0070_0000, "R1 control word", 64'(rd), 64'h0070_0000);
    rstN = 1'b1;
    @(negedge clk);

    // R2 base alignment
    regWrite(4'h0, 32'h3456_78FF, 4'hF);
    regWrite(4'h4, 32'h0000_0012, 4'hF);
    regRead(4'h0, rd);
    check(rd === 32'h3456_7880, "R2 low base forced alignment", 64'(rd), 64'h3456_7880);
    regRead(4'h4, rd);
    check(rd === 32'h12, "R2 upper base", 64'(rd), 64'h12);

    // R3 stopped engine ignores responses
    regWrite(4'h8, 32'h0003_0000, 4'b1100);
    @(negedge clk);
    rspValid = 1'b1; rspData = 64'hDEAD;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(rspReady === 1'b0 && memWrValid === 1'b0, "R3 stopped no accept", {62'b0, rspReady, memWrValid}, 64'd0);
    end
    rspValid = 1'b0;
    regRead(4'h8, rd);
    check(rd[7:0] === 8'd0, "R3 index unchanged while stopped", 64'(rd[7:0]), 64'd0);

    // table walk: depth 2 (R6 code 00), interrupt count 3 (R9)
    regWrite(4'hC, 32'h0000_0002, 4'b0001);
    regRead(4'hC, rd);
    check(rd[1] === 1'b1, "R8 run reads set", 64'(rd[1]), 64'd1);
    for (int v = 0; v < 5; v++) begin
      sendRsp(VECS[v].data, int'(VECS[v].stall), VECS[v].idx);
      check(irq === VECS[v].irqExp, "R9 interrupt after N responses", 64'(irq), 64'(VECS[v].irqExp));
    end
    regRead(4'hC, rd);
    check(rd[8] === 1'b1, "R9 status bit", 64'(rd[8]), 64'd1);
    regWrite(4'hC, 32'h0000_0100, 4'b0010);
    check(irq === 1'b0, "R10 write-one clear", 64'(irq), 64'd0);
    sendRsp(64'h6, 0, 8'd0);
    check(irq === 1'b1, "R9 count restarts", 64'(irq), 64'd1);
    regWrite(4'hC, 32'h0000_0100, 4'b0010);

    // R10 zero count never fires
    regWrite(4'h8, 32'h0000_0000, 4'b1100);

    // R6 depth 16, R7 index reset
    regWrite(4'hC, 32'h0001_0000, 4'b0100);
    regWrite(4'h8, 32'h0000_8000, 4'b0010);
    curIdx = 8'd0;
    regRead(4'h8, rd);
    check(rd[7:0] === 8'd0, "R7 index reset", 64'(rd[7:0]), 64'd0);
    for (int k = 1; k <= 17; k++) sendRsp(64'(k) << 8, k % 3, 8'(k % 16));
    check(curIdx === 8'd1, "R6 depth 16 wrap", 64'(curIdx), 64'd1);
    check(irq === 1'b0, "R10 zero count no interrupt", 64'(irq), 64'd0);

    // R6 depth 256 and reserved code
    regWrite(4'hC, 32'h0002_0000, 4'b0100);
    regWrite(4'hC, 32'h0003_0000, 4'b0100);
    regRead(4'hC, rd);
    check(rd[23:16] === 8'h72, "R6 reserved code ignored, caps", 64'(rd[23:16]), 64'h72);
    regWrite(4'h8, 32'h0000_8000, 4'b0010);
    curIdx = 8'd0;
    for (int k = 1; k <= 256; k++) sendRsp(64'(k), 0, 8'(k % 256));
    check(curIdx === 8'd0, "R6 depth 256 wrap", 64'(curIdx), 64'd0);

    // R8 stop during outstanding write
    @(negedge clk);
    rspValid = 1'b1; rspData = 64'h77;
    while (!rspReady) @(negedge clk);
    @(negedge clk);
    rspValid = 1'b0;
    regWrite(4'hC, 32'h0000_0000, 4'b0001);
    regRead(4'hC, rd);
    check(rd[1] === 1'b1, "R8 run held while write pending", 64'(rd[1]), 64'd1);
    memWrReady = 1'b1;
    @(negedge clk);
    memWrReady = 1'b0;
    regRead(4'hC, rd);
    check(rd[1] === 1'b0, "R8 run clears after completion", 64'(rd[1]), 64'd0);
    regRead(4'h8, rd);
    check(rd[7:0] === 8'd1, "R5 index after final write", 64'(rd[7:0]), 64'd1);
    @(negedge clk);
    check(rspReady === 1'b0, "R3 ready low after stop", 64'(rspReady), 64'd0);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule